// File: doc/BRIEF.md
# Predicated Vector Signed Maximum

This block computes a lane-by-lane signed maximum of two wide vectors and merges the result into the first vector under a predicate mask. The vector has a fixed width set by a parameter. It is split into lanes of 8, 16, 32 or 64 bits, and a 2-bit size code picks the lane width on every operation. The first operand is also the destination. Each lane whose predicate is active takes the larger of the two operand lanes, both read as two's-complement numbers. Each inactive lane keeps the first operand's value.

The predicate has one bit per byte of the vector. A lane's activity comes from the predicate bit of the lowest-addressed byte in that lane. The result is registered and appears one clock after the input strobe, together with an output strobe. The block has no flags and no status outputs.

Top module: `vsmax_unit`

## Requirements
- R1: In an active lane, the output lane equals the larger of the lanes of `opa` and `opb`, with both compared as two's-complement signed integers.
- R2: In an inactive lane, the output lane equals the lane of `opa` unchanged. When `pred` is all zeros, `result` equals `opa`.
- R3: Lane k is active when bit `pred[k*E/8]` is 1, where E is the lane width in bits. The other predicate bits that cover the lane have no effect.
- R4: `size_code` selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b10 gives 32 bits and 2'b11 gives 64 bits.
- R5: The vector holds VEC_W/E lanes, and every lane is processed. This includes the highest lane, which occupies bits VEC_W-1 down to VEC_W-E.
- R6: `out_valid` is high in exactly the cycle after `in_valid` was high. `result` then holds the outcome of that input.
- R7: A synchronous active-high `rst` drives `out_valid` low from the next clock edge, including when `in_valid` is high at that edge.
- R8: When the lanes of the two operands are equal, the output equals `opa`. When a lane compares the most negative value with the most positive value, the most positive value is selected.
- R9: VEC_W is a parameter that defaults to 256 and must be a multiple of 64. The width of `pred` is VEC_W/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation strobe |
| size_code | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64) |
| opa | input | VEC_W | First operand and merge source |
| opb | input | VEC_W | Second operand |
| pred | input | VEC_W/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | VEC_W | Merged maximum vector |

## Verification
Random operands are run under random predicates at all four lane widths. A lane boundary or sign error then shows up as a mismatch in some lane. Directed patterns place the most negative value against the most positive value at each width, which separates a signed compare from an unsigned one. Other directed cases are equal operands, an all-zero predicate and a predicate that sets only the non-lowest bytes of each lane. That last pattern separates the lowest-byte rule from any other way of reading the bits. A case confined to the top lane shows that the last lane is not dropped, and a reset during a strobe shows that the output strobe is cleared.

// File: rtl/vsmax_pkg.sv
package vsmax_pkg;
   typedef enum logic [1:0] {
      SZ_B8  = 2'b00,
      SZ_B16 = 2'b01,
      SZ_B32 = 2'b10,
      SZ_B64 = 2'b11
   } vsmax_size_e;

   localparam int NUM_SIZES = 4;

   function automatic int lane_bits(input int idx);
      return 8 << idx;
   endfunction
endpackage

// File: rtl/vsmax_lanes.sv
module vsmax_lanes #(
   parameter int VEC_W = 256,
   parameter int ESIZE = 8
) (
   input  logic [VEC_W-1:0]       opa,
   input  logic [VEC_W-1:0]       opb,
   input  logic [VEC_W/ESIZE-1:0] act,
   output logic [VEC_W-1:0]       res
);
   localparam int LANES = VEC_W / ESIZE;

   if (ESIZE != 8 && ESIZE != 16 && ESIZE != 32 && ESIZE != 64) begin : g_bad_esize
      $error("vsmax_lanes: ESIZE must be 8, 16, 32 or 64");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [ESIZE-1:0] la;
      logic signed [ESIZE-1:0] lb;
      logic        [ESIZE-1:0] mx;
      assign la = opa[l*ESIZE +: ESIZE];
      assign lb = opb[l*ESIZE +: ESIZE];
      assign mx = (la > lb) ? la : lb;
      assign res[l*ESIZE +: ESIZE] = act[l] ? mx : opa[l*ESIZE +: ESIZE];
   end
endmodule

// File: rtl/vsmax_pick.sv
module vsmax_pick
   import vsmax_pkg::*;
#(
   parameter int VEC_W = 256
) (
   input  logic [1:0]                     size_code,
   input  logic [NUM_SIZES-1:0][VEC_W-1:0] cand,
   output logic [VEC_W-1:0]               sel
);
   vsmax_size_e sz;
   assign sz = vsmax_size_e'(size_code);

   always_comb begin
      unique case (sz)
         SZ_B8:   sel = cand[0];
         SZ_B16:  sel = cand[1];
         SZ_B32:  sel = cand[2];
         default: sel = cand[3];
      endcase
   end
endmodule

// File: rtl/vsmax_unit.sv
module vsmax_unit
   import vsmax_pkg::*;
#(
   parameter int VEC_W = 256
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [1:0]         size_code,
   input  logic [VEC_W-1:0]   opa,
   input  logic [VEC_W-1:0]   opb,
   input  logic [VEC_W/8-1:0] pred,
   output logic               out_valid,
   output logic [VEC_W-1:0]   result
);
   localparam int PRED_W = VEC_W / 8;

   if (VEC_W < 64 || (VEC_W % 64) != 0) begin : g_bad_width
      $error("vsmax_unit: VEC_W must be a positive multiple of 64");
   end

   logic [NUM_SIZES-1:0][VEC_W-1:0] cand;
   logic [VEC_W-1:0]                merged;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int ES     = lane_bits(s);
      localparam int NL     = VEC_W / ES;
      localparam int STRIDE = ES / 8;
      logic [NL-1:0] act;
      for (genvar l = 0; l < NL; l++) begin : g_act
         assign act[l] = pred[l*STRIDE];
      end
      vsmax_lanes #(.VEC_W(VEC_W), .ESIZE(ES)) lanes_i (
         .opa (opa),
         .opb (opb),
         .act (act),
         .res (cand[s])
      );
   end

   vsmax_pick #(.VEC_W(VEC_W)) pick_i (
      .size_code (size_code),
      .cand      (cand),
      .sel       (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) result <= merged;
   end

   if (PRED_W * 8 != VEC_W) begin : g_bad_pred
      $error("vsmax_unit: predicate width mismatch");
   end
endmodule

// File: rtl/vsmax_chk.sv
module vsmax_chk #(
   parameter int VEC_W = 256
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic [1:0]         size_code,
   input logic [VEC_W-1:0]   opa,
   input logic [VEC_W-1:0]   opb,
   input logic [VEC_W/8-1:0] pred,
   input logic               out_valid,
   input logic [VEC_W-1:0]   result
);
   // R6: the output strobe follows the input strobe by one cycle
   p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_valid_cause_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   // R7: reset clears the output strobe at the next edge
   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R2: an all-zero predicate passes the first operand through
   p_no_pred_pass_r2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(pred) == '0) |-> result == $past(opa));

   // R8: equal operands give the first operand back
   p_equal_ops_r8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(opa) == $past(opb)) |-> result == $past(opa));

   // R1: the lowest byte lane is at least as large as both inputs when active
   p_low_lane_max_r1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(size_code) == 2'b00 && $past(pred[0]))
      |-> ($signed(result[7:0]) >= $signed($past(opa[7:0])) &&
           $signed(result[7:0]) >= $signed($past(opb[7:0]))));
endmodule

bind vsmax_unit vsmax_chk #(.VEC_W(VEC_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .size_code (size_code),
   .opa       (opa),
   .opb       (opb),
   .pred      (pred),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/vsmax_unit_tb_top.sv
module vsmax_unit_tb_top;
   localparam int VEC_W  = 256;
   localparam int PRED_W = VEC_W / 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [1:0]        size_code = 2'b00;
   logic [VEC_W-1:0]  opa = '0;
   logic [VEC_W-1:0]  opb = '0;
   logic [PRED_W-1:0] pred = '0;
   logic              out_valid;
   logic [VEC_W-1:0]  result;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   vsmax_unit #(.VEC_W(VEC_W)) dut_i (
      .clk (clk), .rst (rst), .in_valid (in_valid), .size_code (size_code),
      .opa (opa), .opb (opb), .pred (pred),
      .out_valid (out_valid), .result (result)
   );

   function automatic logic [VEC_W-1:0] model(input logic [1:0] sz,
      input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
      input logic [PRED_W-1:0] p);
      int esz = 8 << sz;
      logic [63:0] msk = (esz == 64) ? '1 : ((64'd1 << esz) - 64'd1);
      logic [VEC_W-1:0] r = a;
      for (int l = 0; l < VEC_W / esz; l++) begin
         logic [63:0] xa = 64'(a >> (l*esz)) & msk;
         logic [63:0] xb = 64'(b >> (l*esz)) & msk;
         if (xa[esz-1]) xa = xa | ~msk;
         if (xb[esz-1]) xb = xb | ~msk;
         if (p[l*esz/8]) begin
            logic [63:0] m = ($signed(xa) > $signed(xb)) ? xa : xb;
            r = (r & ~(VEC_W'(msk) << (l*esz))) | (VEC_W'(m & msk) << (l*esz));
         end
      end
      return r;
   endfunction

   function automatic logic [VEC_W-1:0] rnd_vec();
      logic [VEC_W-1:0] v;
      for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   function automatic logic [VEC_W-1:0] fill(input logic [1:0] sz, input logic [63:0] val);
      int esz = 8 << sz;
      logic [VEC_W-1:0] v = '0;
      for (int l = 0; l < VEC_W / esz; l++)
         for (int k = 0; k < esz; k++) v[l*esz + k] = val[k];
      return v;
   endfunction

   task automatic check1(input string tag, input logic [VEC_W-1:0] act,
                         input logic [VEC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [1:0] sz,
      input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
      input logic [PRED_W-1:0] p);
      @(negedge clk);
      size_code = sz; opa = a; opb = b; pred = p; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check1({tag, " R6 strobe"}, VEC_W'(out_valid), VEC_W'(1));
      check1(tag, result, model(sz, a, b, p));
      @(negedge clk);
      check1({tag, " R6 strobe low"}, VEC_W'(out_valid), VEC_W'(0));
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R7: reset state
      check1("R7 reset", VEC_W'(out_valid), VEC_W'(0));
      // R9: predicate width
      check1("R9 pred width", VEC_W'($bits(pred)), VEC_W'(VEC_W / 8));

      // R2: no active lanes
      run_op("R2 pred zero", 2'b01, rnd_vec(), rnd_vec(), '0);
      // R8: equal operands
      begin
         logic [VEC_W-1:0] v = rnd_vec();
         run_op("R8 equal", 2'b10, v, v, '1);
      end
      // R8 R4: most negative vs most positive at each width
      for (int s = 0; s < 4; s++) begin
         int esz = 8 << s;
         logic [63:0] mn = 64'd1 << (esz - 1);
         logic [63:0] mx = mn - 64'd1;
         run_op("R8 R4 extremes", 2'(s), fill(2'(s), mn), fill(2'(s), mx), '1);
         run_op("R8 R4 extremes swapped", 2'(s), fill(2'(s), mx), fill(2'(s), mn), '1);
      end
      // R3: only non-lowest bytes set, lanes stay inactive
      run_op("R3 upper bytes 16", 2'b01, fill(2'b01, 64'h8000), fill(2'b01, 64'h7FFF),
             {(PRED_W/2){2'b10}});
      run_op("R3 upper bytes 64", 2'b11, fill(2'b11, 64'd1), fill(2'b11, 64'd5),
             {(PRED_W/8){8'hFE}});
      run_op("R3 lowest byte only 32", 2'b10, fill(2'b10, 64'd1), fill(2'b10, 64'd9),
             {(PRED_W/4){4'b0001}});
      // R5: the top lane is processed
      begin
         logic [VEC_W-1:0] b = '0;
         b[VEC_W-1 -: 64] = 64'h0000_0000_0000_1234;
         run_op("R5 top lane 64", 2'b11, '0, b, {8'h01, {(PRED_W-8){1'b0}}});
         b = '0; b[VEC_W-1 -: 8] = 8'h44;
         run_op("R5 top lane 8", 2'b00, '0, b, {1'b1, {(PRED_W-1){1'b0}}});
      end
      // R7: reset while a strobe is presented
      @(negedge clk);
      in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b0;
      check1("R7 reset over strobe", VEC_W'(out_valid), VEC_W'(0));
      // R1 R4: random operations
      for (int i = 0; i < 200; i++) begin
         logic [1:0] sz = 2'($urandom_range(0, 3));
         logic [VEC_W-1:0] a = rnd_vec();
         logic [VEC_W-1:0] b = (i % 5 == 0) ? (a ^ (VEC_W'(1) << $urandom_range(0, VEC_W-1)))
                                            : rnd_vec();
         logic [PRED_W-1:0] p = PRED_W'(rnd_vec());
         run_op("R1 R4 random", sz, a, b, p);
      end
      // R6: back-to-back strobes
      @(negedge clk);
      size_code = 2'b00; opa = rnd_vec(); opb = rnd_vec(); pred = '1; in_valid = 1'b1;
      @(negedge clk);
      check1("R6 back-to-back first", result, model(2'b00, opa, opb, pred));
      opa = rnd_vec();
      @(negedge clk);
      in_valid = 1'b0;
      check1("R6 back-to-back second", result, model(2'b00, opa, opb, pred));
      check1("R6 back-to-back strobe", VEC_W'(out_valid), VEC_W'(1));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule